// File: doc/BRIEF.md
# Audio Error Concealment and Mute Stage

This block sits at the end of a disc playback audio path. It receives a stream of signed 16-bit samples from the error-correction stage. Left and right samples are interleaved, and each sample carries a pointer bit that marks it as uncorrectable. Each channel keeps its own one-sample delay. A flagged sample is therefore decided only once the next sample of the same channel is known:

- If that next sample is good, the flagged one is replaced by the mean of the last emitted value and the next sample.
- If the next sample is also flagged, the last emitted value is held.

A run of flagged samples is thus filled by holding the last good value. Its last member is bridged to the first good sample by a mean.

After concealment, the sample passes an output shaper. The shaper applies attenuation, hard mute, or a mute that waits for a sample close to zero. The choice depends on two configuration bits and a mute input. A bypass bit turns concealment off for data that must not be altered. The pointer bit travels with each output sample so that later stages can use it.

Top module: `audio_conceal_top`

## Requirements
- R1: A flagged sample whose next same-channel sample is unflagged is output as the mean of the previous output value of that channel and that next sample: floor((a+b)/2), computed on signed 17-bit sums.
- R2: A flagged sample whose next same-channel sample is also flagged is output as the previous output value of that channel, so runs of three or more are filled by hold and the last member of a run is averaged (R1) with the next good sample.
- R3: The two channels are concealed independently. in_left=1 marks a left sample and in_left=0 a right sample, and out_left carries the channel of each output sample. After reset the value used as "previous output" is 0 for both channels.
- R4: Each channel is delayed by one sample. An accepted sample is output in the cycle after the next sample of the same channel is accepted, with out_valid high for exactly that cycle. The first sample of each channel after reset produces no output.
- R5: With cfg_bypass=1 every sample is output unchanged, flagged or not, and the unchanged value becomes the channel's previous output value.
- R6: With cfg_atten=0, cfg_zc_en=0 and mute_in=1, every output sample is 0.
- R7: With cfg_atten=0, cfg_zc_en=1 and mute_in=1, samples pass unchanged until one whose upper 6 bits are all ones (values -1024 to -1). That sample and all later ones are output as 0 until mute_in is seen low, which re-arms the wait.
- R8: With cfg_atten=1 the output is the concealed value arithmetically shifted right by 2 (about -12 dB), whatever mute_in is.
- R9: out_err equals the pointer bit of the sample being output.
- R10: After reset, out_valid and out_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | 1 | Channel of input sample, 1 = left, 0 = right |
| in_data | input | 16 | Signed input sample |
| in_err | input | 1 | Uncorrectable pointer of input sample |
| cfg_bypass | input | 1 | Disable concealment |
| cfg_zc_en | input | 1 | Mute waits for near-zero sample |
| cfg_atten | input | 1 | Attenuate output by 2-bit shift |
| mute_in | input | 1 | Mute request |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 1 | Channel of output sample |
| out_data | output | 16 | Signed processed sample |
| out_err | output | 1 | Pointer of output sample |

## Verification
A sample is emitted one register stage after the input strobe of the next same-channel sample, so every result is due in the cycle that follows such a strobe. The bench drives inputs on the falling edge and then advances its behavioural model for the same cycle. It compares out_valid, and when valid also the data, channel and pointer, on the next falling edge. Every cycle is compared this way, idle cycles included. Mute and configuration values take effect on the same edge that registers the sample, so the model applies them to that sample.

// File: rtl/audio_conceal_pkg.sv
`timescale 1ns/1ps
package audio_conceal_pkg;

    localparam int unsigned SMP_W = 16;

    typedef logic signed [SMP_W-1:0] smp_t;

    typedef struct packed {
        logic err;
        smp_t val;
    } tagged_t;

    typedef enum logic [1:0] {
        ACT_PASS = 2'd0,
        ACT_MEAN = 2'd1,
        ACT_HOLD = 2'd2
    } act_e;

    function automatic smp_t mean2(input smp_t a, input smp_t b);
        logic signed [SMP_W:0] s;
        s = {a[SMP_W-1], a} + {b[SMP_W-1], b};
        return s[SMP_W:1];
    endfunction

    function automatic smp_t shrink(input smp_t a, input int unsigned sh);
        return a >>> sh;
    endfunction

endpackage

// File: rtl/conceal_lane.sv
`timescale 1ns/1ps
module conceal_lane
    import audio_conceal_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  logic    bypass,
    input  tagged_t nxt,
    output logic    emit,
    output smp_t    fixed,
    output logic    fixed_err
);

    tagged_t held_q;
    logic    primed_q;
    smp_t    prev_q;
    act_e    act;

    always_comb begin
        if (bypass || !held_q.err) begin
            act = ACT_PASS;
        end else if (nxt.err) begin
            act = ACT_HOLD;
        end else begin
            act = ACT_MEAN;
        end
    end

    always_comb begin
        unique case (act)
            ACT_MEAN: fixed = mean2(prev_q, nxt.val);
            ACT_HOLD: fixed = prev_q;
            default:  fixed = held_q.val;
        endcase
    end

    assign emit      = load && primed_q;
    assign fixed_err = held_q.err;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= '0;
            primed_q <= 1'b0;
            prev_q   <= '0;
        end else if (load) begin
            held_q   <= nxt;
            primed_q <= 1'b1;
            if (primed_q) begin
                prev_q <= fixed;
            end
        end
    end

endmodule

// File: rtl/out_shaper.sv
`timescale 1ns/1ps
module out_shaper
    import audio_conceal_pkg::*;
#(
    parameter int unsigned ZC_BITS = 6,
    parameter int unsigned ATT_SH  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic emit,
    input  logic emit_left,
    input  smp_t emit_val,
    input  logic emit_err,
    input  logic cfg_zc_en,
    input  logic cfg_atten,
    input  logic mute_in,
    output logic out_valid,
    output logic out_left,
    output smp_t out_data,
    output logic out_err
);

    logic zc_hit_q;
    logic near_zero;
    smp_t shaped;

    assign near_zero = (emit_val[SMP_W-1 -: ZC_BITS] == {ZC_BITS{1'b1}});

    always_comb begin
        if (cfg_atten) begin
            shaped = shrink(emit_val, ATT_SH);
        end else if (mute_in) begin
            if (cfg_zc_en && !(zc_hit_q || near_zero)) begin
                shaped = emit_val;
            end else begin
                shaped = '0;
            end
        end else begin
            shaped = emit_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zc_hit_q <= 1'b0;
        end else if (!mute_in) begin
            zc_hit_q <= 1'b0;
        end else if (emit && cfg_zc_en && near_zero) begin
            zc_hit_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_left  <= 1'b0;
            out_data  <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_left <= emit_left;
                out_data <= shaped;
                out_err  <= emit_err;
            end
        end
    end

endmodule

// File: rtl/audio_conceal_top.sv
`timescale 1ns/1ps
module audio_conceal_top
    import audio_conceal_pkg::*;
#(
    parameter int unsigned ZC_BITS = 6,
    parameter int unsigned ATT_SH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_left,
    input  logic [SMP_W-1:0] in_data,
    input  logic             in_err,
    input  logic             cfg_bypass,
    input  logic             cfg_zc_en,
    input  logic             cfg_atten,
    input  logic             mute_in,
    output logic             out_valid,
    output logic             out_left,
    output logic [SMP_W-1:0] out_data,
    output logic             out_err
);

    localparam int unsigned N_CH = 2;

    tagged_t         nxt;
    logic [N_CH-1:0] emit_v;
    logic [N_CH-1:0] err_v;
    smp_t            fix_v [N_CH];
    smp_t            sel_val;
    smp_t            shaped_out;

    assign nxt.err = in_err;
    assign nxt.val = smp_t'(in_data);

    for (genvar g = 0; g < N_CH; g++) begin : g_lane
        conceal_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .load      (in_valid && (in_left == g[0])),
            .bypass    (cfg_bypass),
            .nxt       (nxt),
            .emit      (emit_v[g]),
            .fixed     (fix_v[g]),
            .fixed_err (err_v[g])
        );
    end

    assign sel_val = in_left ? fix_v[1] : fix_v[0];

    out_shaper #(
        .ZC_BITS (ZC_BITS),
        .ATT_SH  (ATT_SH)
    ) u_shape (
        .clk       (clk),
        .rst       (rst),
        .emit      (|emit_v),
        .emit_left (in_left),
        .emit_val  (sel_val),
        .emit_err  (in_left ? err_v[1] : err_v[0]),
        .cfg_zc_en (cfg_zc_en),
        .cfg_atten (cfg_atten),
        .mute_in   (mute_in),
        .out_valid (out_valid),
        .out_left  (out_left),
        .out_data  (shaped_out),
        .out_err   (out_err)
    );

    assign out_data = shaped_out;

endmodule

// File: rtl/audio_conceal_checker.sv
`timescale 1ns/1ps
module audio_conceal_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_left,
    input logic        cfg_zc_en,
    input logic        cfg_atten,
    input logic        mute_in,
    input logic        out_valid,
    input logic        out_left,
    input logic [15:0] out_data
);

    p_valid_needs_input_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    p_left_tag_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_left == $past(in_left)));

    p_hard_mute_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(mute_in && !cfg_zc_en && !cfg_atten)) |-> (out_data == 16'd0));

    p_atten_sign_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(cfg_atten)) |-> (out_data[15:13] == 3'b000 || out_data[15:13] == 3'b111));

    p_zc_zeroed_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(mute_in && cfg_zc_en && !cfg_atten)) |-> (out_data[15:10] != 6'h3F));

endmodule

bind audio_conceal_top audio_conceal_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .cfg_zc_en (cfg_zc_en),
    .cfg_atten (cfg_atten),
    .mute_in   (mute_in),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_data  (out_data)
);

// File: tb/sim_audio_conceal_top.sv
`timescale 1ns/1ps
module sim_audio_conceal_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_left = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_err = 1'b0;
    logic        cfg_bypass = 1'b0;
    logic        cfg_zc_en = 1'b0;
    logic        cfg_atten = 1'b0;
    logic        mute_in = 1'b0;
    logic        out_valid;
    logic        out_left;
    logic [15:0] out_data;
    logic        out_err;

    int n_checks = 0;
    int n_errors = 0;
    string tag = "R10";

    // behavioural reference state
    int m_held   [2];
    bit m_herr   [2];
    bit m_primed [2];
    int m_prev   [2];
    bit m_zc;
    bit e_valid;
    int e_data;
    bit e_left;
    bit e_err;

    always #2.5 clk = ~clk;

    audio_conceal_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left),
        .in_data(in_data), .in_err(in_err), .cfg_bypass(cfg_bypass),
        .cfg_zc_en(cfg_zc_en), .cfg_atten(cfg_atten), .mute_in(mute_in),
        .out_valid(out_valid), .out_left(out_left), .out_data(out_data),
        .out_err(out_err)
    );

    task automatic check(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_held[c] = 0; m_herr[c] = 0; m_primed[c] = 0; m_prev[c] = 0;
        end
        m_zc = 0;
    endtask

    task automatic model_step(input bit v, input bit l, input int d, input bit e);
        int  fx;
        bit  near;
        int  ch;
        e_valid = 0;
        near = 0;
        if (v) begin
            ch = l ? 1 : 0;
            if (m_primed[ch]) begin
                if (cfg_bypass || !m_herr[ch]) fx = m_held[ch];
                else if (e) fx = m_prev[ch];
                else fx = (m_prev[ch] + d) >>> 1;
                near = (fx < 0) && (fx >= -1024);
                if (cfg_atten) e_data = fx >>> 2;
                else if (mute_in) e_data = (cfg_zc_en && !(m_zc || near)) ? fx : 0;
                else e_data = fx;
                e_valid = 1;
                e_left = l;
                e_err = m_herr[ch];
                m_prev[ch] = fx;
            end
            m_held[ch] = d;
            m_herr[ch] = e;
            m_primed[ch] = 1;
        end
        if (!mute_in) m_zc = 0;
        else if (e_valid && cfg_zc_en && near) m_zc = 1;
    endtask

    task automatic push(input bit v, input bit l, input int d, input bit e);
        in_valid = v; in_left = l; in_data = d[15:0]; in_err = e;
        model_step(v, l, d, e);
        @(posedge clk);
        @(negedge clk);
        in_valid = 0;
        check("out_valid", int'(out_valid), int'(e_valid));
        if (e_valid) begin
            check("out_data", int'($signed(out_data)), e_data);
            check("out_left", int'(out_left), int'(e_left));
            check("out_err (R9)", int'(out_err), int'(e_err));
        end
    endtask

    initial begin
        #(200000 * 5);
        n_errors++;
        $display("FAIL watchdog expired in %s", tag);
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        tag = "R10";
        check("reset out_valid", int'(out_valid), 0);
        check("reset out_data", int'(out_data), 0);

        // R4: priming, one-sample delay, idle cycles
        tag = "R4";
        push(1, 1, 100, 0);
        push(1, 0, -200, 0);
        push(0, 0, 0, 0);
        push(1, 1, 300, 0);
        push(1, 0, -400, 0);
        push(0, 1, 0, 0);

        // R1: isolated flagged sample, left channel, with right interleaved
        tag = "R1";
        push(1, 1, 1000, 0);
        push(1, 1, 7777, 1);
        push(1, 0, 50, 0);
        push(1, 1, 2001, 0);
        push(1, 1, -3, 0);
        push(1, 1, 1234, 1);
        push(1, 1, 0, 0);
        push(1, 1, 10, 0);

        // R2: run of three flagged, then good
        tag = "R2";
        push(1, 0, 500, 0);
        push(1, 0, 11, 1);
        push(1, 0, 22, 1);
        push(1, 0, 33, 1);
        push(1, 0, 900, 0);
        push(1, 0, 901, 0);
        push(1, 0, 5, 1);
        push(1, 0, 6, 1);
        push(1, 0, -700, 0);
        push(1, 0, -701, 0);

        // R3: independent channels, flags on both
        tag = "R3";
        push(1, 1, 3000, 1);
        push(1, 0, -3000, 1);
        push(1, 1, 4000, 0);
        push(1, 0, -4000, 0);
        push(1, 1, 1, 0);
        push(1, 0, 2, 0);

        // R5: bypass keeps flagged values
        tag = "R5";
        cfg_bypass = 1;
        push(1, 1, 1111, 1);
        push(1, 1, 2222, 1);
        push(1, 1, 3333, 0);
        push(1, 1, 4444, 0);
        cfg_bypass = 0;
        push(1, 1, 55, 1);
        push(1, 1, 66, 0);

        // R6: hard mute
        tag = "R6";
        mute_in = 1;
        push(1, 0, 12345, 0);
        push(1, 0, -12345, 0);
        push(1, 1, 777, 0);
        mute_in = 0;
        push(1, 0, 9, 0);

        // R7: zero-cross mute waits for a near-zero sample
        tag = "R7";
        cfg_zc_en = 1;
        mute_in = 1;
        push(1, 0, 5000, 0);
        push(1, 0, -5, 0);
        push(1, 0, 4000, 0);
        push(1, 0, -20000, 0);
        push(1, 0, 30, 0);
        mute_in = 0;
        push(1, 0, 40, 0);
        mute_in = 1;
        push(1, 0, -1024, 0);
        push(1, 0, 8, 0);
        push(1, 0, 9, 0);
        mute_in = 0;
        cfg_zc_en = 0;
        push(1, 0, 10, 0);

        // R8: attenuation independent of mute
        tag = "R8";
        cfg_atten = 1;
        push(1, 1, -32768, 0);
        push(1, 1, 32767, 0);
        mute_in = 1;
        push(1, 1, -7, 0);
        push(1, 1, 0, 0);
        mute_in = 0;
        cfg_atten = 0;
        push(1, 1, 1, 0);

        // R9: pointer travels with output
        tag = "R9";
        push(1, 0, 100, 1);
        push(1, 0, 200, 0);
        push(1, 0, 300, 1);
        push(1, 0, 400, 1);
        push(1, 0, 500, 0);

        // R10: reset again clears priming and previous values
        tag = "R10";
        rst = 1;
        @(negedge clk);
        rst = 0;
        model_reset();
        check("reset out_valid", int'(out_valid), 0);
        push(1, 1, 8000, 1);
        push(1, 1, 600, 0);
        push(1, 1, 700, 0);

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule